// File: doc/BRIEF.md
# Strap-Configured Dual-Clock FIFO

This block is an 18-bit first-in first-out buffer whose write side and read side run on separate, unrelated clocks. Each side has its own enable. Pointers cross between the two clock domains as Gray codes through two-flop synchronizers. Because of that two-stage crossing, every flag that depends on the opposite domain reaches its new value only after two local clock edges.

Three strap inputs are sampled while reset is held low, and they fix the read-side timing until the next reset. In standard mode the read-side flag reports that the buffer is empty, and a word reaches the output register only when a read enable is given. In fall-through mode the first word moves into the output register without any request, and the read-side flag then reports that the output holds valid data. The write-side flag means "full" in standard mode and "ready to accept" in fall-through mode. A half-full flag reports occupancy as seen from the write side. An active-low output enable gates the data output; the high-impedance state is modelled as a cleared valid bit with zeroed data.

Top module: `strapFifo`

## Requirements
- R1: After reset in standard mode, rdFlag=1, wrFlag=0, halfFull=0 and rdData=0. After reset in fall-through mode, rdFlag=0 and wrFlag=1.
- R2: The straps {cfgFirst,cfgRdExp,cfgWrExp} are sampled on clock edges only while rstN=0. The codes 3'b001 and 3'b101 select fall-through mode, and every other code selects standard mode. Changing the straps after reset has no effect.
- R3: In standard mode, rdEn=1 at a read edge while the buffer is not empty loads the oldest unread word into rdData at that edge. Words leave in the order they were written.
- R4: In standard mode, after a write into an empty buffer, rdFlag stays 1 through the first read edge that follows the write edge. It falls at the second read edge, provided the write edge leads that first read edge. If the edges coincide, the fall may take one more read edge.
- R5: In standard mode, rdEn while rdFlag=1 does nothing: rdData keeps the last word read and rdFlag stays 1.
- R6: In fall-through mode, a word written into an empty buffer appears on rdData, with rdFlag rising to 1, at the third read edge after the write edge, with no rdEn. rdFlag is still 0 after the second read edge.
- R7: In fall-through mode, the word on rdData is held while rdEn=0. rdEn at a read edge with rdFlag=1 presents the next word, or clears rdFlag if no word remains, leaving rdData unchanged. rdEn while rdFlag=0 is ignored.
- R8: After DEPTH writes with no reads, the buffer is full: wrFlag=1 in standard mode. Writes while full are discarded, so reading back returns exactly the DEPTH stored words and then empty.
- R9: halfFull=1 exactly when the write-side occupancy exceeds DEPTH/2. It updates at the write edge that changes the count.
- R10: With outEnN=1, rdData=0 and rdValid=0. With outEnN=0, rdValid=1 and rdData shows the output register, which is unaffected by outEnN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| wrEn | input | 1 | Write enable, active high |
| wrData | input | 18 | Write data |
| rdClk | input | 1 | Read clock |
| rdEn | input | 1 | Read enable, active high |
| outEnN | input | 1 | Output enable, active low |
| rdData | output | 18 | Read data, zero when the output is disabled |
| rdValid | output | 1 | Output driven (high-impedance model) |
| rstN | input | 1 | Asynchronous reset, active low; straps are sampled while it is low |
| cfgFirst | input | 1 | Strap bit 2 |
| cfgRdExp | input | 1 | Strap bit 1 |
| cfgWrExp | input | 1 | Strap bit 0 |
| wrFlag | output | 1 | Full (standard mode) or ready to accept (fall-through mode) |
| rdFlag | output | 1 | Empty (standard mode) or output ready (fall-through mode) |
| halfFull | output | 1 | Occupancy above DEPTH/2 |

## Verification
The bench places each read edge 3 ns after a write edge and checks flag timing edge by edge. A crossing that drops a synchronizer stage would clear the empty flag one edge early, and one that adds a stage would set the ready flag late. It fills the buffer, pushes extra words, and reads everything back. A full check that is off by one would either lose the last word or let the extra words overwrite the oldest entries. It also issues reads on an empty buffer in both modes, flips the straps after reset, and toggles the output enable while a word is held. A design that advanced its pointer on an empty read, re-decoded the mode at any time, or let the output enable disturb the output register would show a wrong word or flag.

// File: rtl/strapFifoPkg.sv
package strapFifoPkg;
  localparam int DATA_W = 18;

  typedef enum logic {MODE_STD = 1'b0, MODE_FALL = 1'b1} fifoMode_t;

  typedef struct packed {
    logic wrStb;    // write-domain: store wrData at wrAddr
    logic loadStb;  // read-domain: move word at rdAddr into output register
  } fifoStrobes_t;

  function automatic fifoMode_t decodeMode(input logic [2:0] straps);
    return (straps inside {3'b001, 3'b101}) ? MODE_FALL : MODE_STD;
  endfunction
endpackage

// File: rtl/strapFifoCtrl.sv
module strapFifoCtrl
  import strapFifoPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       wrClk,
  input  logic                       rdClk,
  input  logic                       rstN,
  input  logic [2:0]                 straps,
  input  logic                       wrEn,
  input  logic                       rdEn,
  output fifoStrobes_t               strobes,
  output logic [$clog2(DEPTH)-1:0]   wrAddr,
  output logic [$clog2(DEPTH)-1:0]   rdAddr,
  output logic                       wrFlag,
  output logic                       rdFlag,
  output logic                       halfFull
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int PTR_W  = ADDR_W + 1;

  function automatic logic [PTR_W-1:0] binToGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] grayToBin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  fifoMode_t wrMode, rdMode;

  // Straps are only looked at while reset holds
  always_ff @(posedge wrClk) if (!rstN) wrMode <= decodeMode(straps);
  always_ff @(posedge rdClk) if (!rstN) rdMode <= decodeMode(straps);

  // ---------------- write domain ----------------
  logic [PTR_W-1:0] wrBin, wrGray, rdGrayS1, rdGrayS2, rdBinSync, occWr;
  logic             isFull;

  assign rdBinSync = grayToBin(rdGrayS2);
  assign occWr     = wrBin - rdBinSync;
  assign isFull    = (occWr == PTR_W'(DEPTH));

  // ---------------- read domain -----------------
  logic [PTR_W-1:0] rdBin, rdGray, wrGrayS1, wrGrayS2, wrBinSync;
  logic             memEmpty, readyReg;

  assign wrBinSync = grayToBin(wrGrayS2);
  assign memEmpty  = (rdBin == wrBinSync);

  always_comb begin
    strobes.wrStb = wrEn && !isFull;
    if (rdMode == MODE_FALL) strobes.loadStb = !memEmpty && (!readyReg || rdEn);
    else                     strobes.loadStb = rdEn && !memEmpty;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (strobes.wrStb) begin
        wrBin  <= wrBin + 1'b1;
        wrGray <= binToGray(wrBin + 1'b1);
      end
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
      readyReg <= 1'b0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (strobes.loadStb) begin
        rdBin  <= rdBin + 1'b1;
        rdGray <= binToGray(rdBin + 1'b1);
      end
      if (rdMode == MODE_FALL) begin
        if (strobes.loadStb) readyReg <= 1'b1;
        else if (rdEn)       readyReg <= 1'b0;
      end else begin
        readyReg <= 1'b0;
      end
    end
  end

  assign wrAddr   = wrBin[ADDR_W-1:0];
  assign rdAddr   = rdBin[ADDR_W-1:0];
  assign wrFlag   = (wrMode == MODE_FALL) ? !isFull : isFull;
  assign rdFlag   = (rdMode == MODE_FALL) ? readyReg : memEmpty;
  assign halfFull = (occWr > PTR_W'(DEPTH / 2));

  // ---------------- assertions ----------------
  a_r8_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    occWr <= PTR_W'(DEPTH));

  a_r8_full_blocks_write: assert property (@(posedge wrClk) disable iff (!rstN)
    (isFull && wrEn) |=> (wrBin == $past(wrBin)));

  a_r4_wr_gray_step: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);

  a_r4_rd_gray_step: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);

  a_r5_empty_read_noop: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdMode == MODE_STD && memEmpty && rdEn) |=> (rdBin == $past(rdBin)));

  a_r7_ready_holds: assert property (@(posedge rdClk) disable iff (!rstN)
    (rdMode == MODE_FALL && readyReg && !rdEn) |=> readyReg);
endmodule

// File: rtl/strapFifoData.sv
module strapFifoData
  import strapFifoPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                       wrClk,
  input  logic                       rdClk,
  input  logic                       rstN,
  input  fifoStrobes_t               strobes,
  input  logic [$clog2(DEPTH)-1:0]   wrAddr,
  input  logic [$clog2(DEPTH)-1:0]   rdAddr,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       outEnN,
  output logic [DATA_W-1:0]          rdData,
  output logic                       rdValid
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (strobes.wrStb) store[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)               outReg <= '0;
    else if (strobes.loadStb) outReg <= store[rdAddr];
  end

  assign rdValid = !outEnN;
  assign rdData  = outEnN ? '0 : outReg;

  a_r3_hold_without_load: assert property (@(posedge rdClk) disable iff (!rstN)
    !strobes.loadStb |=> $stable(outReg));
endmodule

// File: rtl/strapFifo.sv
module strapFifo
  import strapFifoPkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              wrClk,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdEn,
  input  logic              outEnN,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  input  logic              rstN,
  input  logic              cfgFirst,
  input  logic              cfgRdExp,
  input  logic              cfgWrExp,
  output logic              wrFlag,
  output logic              rdFlag,
  output logic              halfFull
);
  localparam int ADDR_W = $clog2(DEPTH);

  fifoStrobes_t      strobes;
  logic [ADDR_W-1:0] wrAddr, rdAddr;

  strapFifoCtrl #(.DEPTH(DEPTH)) ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .straps({cfgFirst, cfgRdExp, cfgWrExp}),
    .wrEn(wrEn), .rdEn(rdEn), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFlag(wrFlag), .rdFlag(rdFlag), .halfFull(halfFull)
  );

  strapFifoData #(.DEPTH(DEPTH)) data (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .outEnN(outEnN), .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: tb/strapFifo_test.sv
module strapFifo_test;
  localparam int DEPTH = 256;

  logic        wrClk, rdClk, rstN;
  logic        wrEn, rdEn, outEnN;
  logic [17:0] wrData, rdData;
  logic        rdValid, cfgFirst, cfgRdExp, cfgWrExp;
  logic        wrFlag, rdFlag, halfFull;
  int          nChecks = 0;
  int          nFails  = 0;

  strapFifo #(.DEPTH(DEPTH)) uut (
    .wrClk(wrClk), .wrEn(wrEn), .wrData(wrData),
    .rdClk(rdClk), .rdEn(rdEn), .outEnN(outEnN),
    .rdData(rdData), .rdValid(rdValid), .rstN(rstN),
    .cfgFirst(cfgFirst), .cfgRdExp(cfgRdExp), .cfgWrExp(cfgWrExp),
    .wrFlag(wrFlag), .rdFlag(rdFlag), .halfFull(halfFull)
  );

  // 100 MHz on both sides; read edges trail write edges by 3 ns
  initial begin wrClk = 1'b0; forever #5 wrClk = ~wrClk; end
  initial begin rdClk = 1'b0; #3; forever #5 rdClk = ~rdClk; end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 37 + 5) ^ (i << 9));
  endfunction

  task automatic doReset(input logic f, input logic r, input logic w);
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; outEnN = 1'b0; wrData = '0;
    cfgFirst = f; cfgRdExp = r; cfgWrExp = w;
    repeat (4) @(posedge rdClk);
    @(negedge wrClk) rstN = 1'b1;
    @(negedge wrClk);
  endtask

  task automatic writeWord(input logic [17:0] d);
    @(negedge wrClk); wrEn = 1'b1; wrData = d;
    @(negedge wrClk); wrEn = 1'b0;
  endtask

  task automatic readPulse();
    @(negedge rdClk); rdEn = 1'b1;
    @(negedge rdClk); rdEn = 1'b0;
  endtask

  task automatic testResetModes();
    doReset(1'b0, 1'b1, 1'b0);
    chk("R1 std empty", rdFlag, 1); chk("R1 std not full", wrFlag, 0);
    chk("R1 halfFull", halfFull, 0); chk("R1 rdData", rdData, 0);
    chk("R10 valid driven", rdValid, 1);
    doReset(1'b1, 1'b0, 1'b1);
    chk("R1 fall rdFlag", rdFlag, 0); chk("R1 fall wrFlag", wrFlag, 1);
    doReset(1'b0, 1'b1, 1'b1);
    chk("R2 code 011 is std", rdFlag, 1);
    doReset(1'b0, 1'b0, 1'b0);
    chk("R2 code 000 is std", wrFlag, 0);
  endtask

  task automatic testStdLatency();
    doReset(1'b0, 1'b1, 1'b0);
    @(negedge wrClk); wrEn = 1'b1; wrData = 18'h1A5;
    @(posedge wrClk); #1 wrEn = 1'b0;
    @(posedge rdClk); #1 chk("R4 still empty after 1st read edge", rdFlag, 1);
    @(posedge rdClk); #1 chk("R4 not empty after 2nd read edge", rdFlag, 0);
    readPulse();
    chk("R3 first word", rdData, 18'h1A5);
    chk("R5 empty again", rdFlag, 1);
    readPulse();
    chk("R5 empty read keeps data", rdData, 18'h1A5);
    chk("R5 empty read keeps flag", rdFlag, 1);
  endtask

  task automatic testStdOrder();
    doReset(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) writeWord(pat(i + 300));
    repeat (4) @(posedge rdClk);
    for (int i = 0; i < 5; i++) begin
      readPulse();
      chk("R3 order", rdData, pat(i + 300));
    end
  endtask

  task automatic testFill();
    doReset(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < DEPTH / 2; i++) writeWord(pat(i));
    chk("R9 at half not set", halfFull, 0);
    writeWord(pat(DEPTH / 2));
    chk("R9 above half set", halfFull, 1);
    for (int i = DEPTH / 2 + 1; i < DEPTH; i++) writeWord(pat(i));
    chk("R8 full", wrFlag, 1);
    for (int i = 0; i < 3; i++) writeWord(18'h3FFFF);
    chk("R8 still full", wrFlag, 1);
    repeat (4) @(posedge rdClk);
    for (int i = 0; i < DEPTH; i++) begin
      readPulse();
      chk("R8 readback", rdData, pat(i));
    end
    repeat (4) @(posedge wrClk);
    #1;
    chk("R8 empty after DEPTH reads", rdFlag, 1);
    chk("R8 not full after drain", wrFlag, 0);
    chk("R9 cleared after drain", halfFull, 0);
  endtask

  task automatic testFall();
    doReset(1'b0, 1'b0, 1'b1);
    chk("R1 fall not ready", rdFlag, 0);
    cfgFirst = 1'b0; cfgRdExp = 1'b1; cfgWrExp = 1'b0;  // std code after reset
    @(negedge wrClk); wrEn = 1'b1; wrData = 18'h2B;
    @(posedge wrClk); #1 wrEn = 1'b0;
    @(posedge rdClk); #1;
    @(posedge rdClk); #1 chk("R6 not ready after 2nd read edge", rdFlag, 0);
    @(posedge rdClk); #1 chk("R6 ready after 3rd read edge", rdFlag, 1);
    chk("R6 first word fell through", rdData, 18'h2B);
    chk("R2 straps ignored after reset", rdFlag, 1);
    writeWord(18'h3C);
    writeWord(18'h4D);
    repeat (6) @(posedge rdClk);
    #1 chk("R7 held without rdEn", rdData, 18'h2B);
    @(negedge rdClk); outEnN = 1'b1;
    #1 chk("R10 disabled data", rdData, 0); chk("R10 disabled valid", rdValid, 0);
    outEnN = 1'b0;
    #1 chk("R10 re-enabled data", rdData, 18'h2B); chk("R10 re-enabled valid", rdValid, 1);
    readPulse();
    chk("R7 second word", rdData, 18'h3C); chk("R7 ready", rdFlag, 1);
    readPulse();
    chk("R7 third word", rdData, 18'h4D);
    readPulse();
    chk("R7 ready drops when drained", rdFlag, 0);
    chk("R7 data kept when drained", rdData, 18'h4D);
    readPulse();
    chk("R7 rdEn ignored when not ready", rdFlag, 0);
    chk("R7 data unchanged", rdData, 18'h4D);
  endtask

  initial begin
    repeat (100000) @(posedge wrClk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    testResetModes();
    testStdLatency();
    testStdOrder();
    testFill();
    testFall();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule